// File: doc/BRIEF.md
# Vector Leftmost-Byte Clear Unit

This unit executes one 128-bit vector operation in a single cycle: it keeps the N least-significant (rightmost) bytes of a source vector and forces every byte to their left to zero. N is taken from a 64-bit scalar operand that is read as an unsigned number, so any value of 16 or more keeps the whole vector.

A 32-bit instruction word is presented with a valid strobe. The unit recognises the single matching encoding and breaks out the target, source-vector and count-register indices. It then builds a 128-bit byte mask from the count as two 64-bit halves and drives the masked vector. The register file reads have already happened, so the vector and count operands arrive as values. The result and its write-enable are combinational. A registered valid flag, which carries the target index, follows one cycle later.

Top module: `vlbc_unit`

## Requirements
- R1: The word is decoded as a match only when bits [31:26] are 6'b000100 and bits [10:0] are 11'b00110001101. `wr_en_o` is high exactly when `insn_valid_i` is high and the word matches.
- R2: `tgt_idx_o` carries insn bits [25:21], `src_idx_o` carries bits [20:16] and `cnt_idx_o` carries bits [15:11], for any word.
- R3: A count of 16 or more, compared as an unsigned 64-bit value (including values with bit 63 set), returns the source vector unchanged.
- R4: A count of 0 returns an all-zero vector.
- R5: A count from 1 to 7 keeps the low `count` bytes of bits [63:0]. All other bits of the result are zero.
- R6: A count from 8 to 15 keeps all of bits [63:0] and the low `count-8` bytes of bits [127:64]. The remaining bytes are zero.
- R7: Byte i of the vector occupies bits [127-8i -: 8], so byte 0 is the leftmost. A count N keeps bytes 16-N through 15 and clears bytes 0 through 15-N.
- R8: One clock edge after `wr_en_o` is high, `res_valid_o` is high and `res_tgt_o` equals the target index of that instruction.
- R9: When an edge samples `wr_en_o` low (a non-matching word or a deasserted valid), `res_valid_o` is low after that edge. While `rst_ni` is low, `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| vsrc_i | input | 128 | Source vector operand value |
| cnt_i | input | 64 | Scalar keep-count operand value |
| tgt_idx_o | output | 5 | Decoded target vector index |
| src_idx_o | output | 5 | Decoded source vector index |
| cnt_idx_o | output | 5 | Decoded scalar count register index |
| result_o | output | 128 | Masked vector result |
| wr_en_o | output | 1 | Result write-enable (combinational) |
| res_valid_o | output | 1 | Registered flag: an instruction completed last cycle |
| res_tgt_o | output | 5 | Registered target index of that instruction |

## Verification
The registered completion flag of one instruction and the combinational decode of the next word fall in the same cycle. The bench provokes this by issuing a matching word and then, one cycle later, a non-matching word. During that second cycle it checks that `res_valid_o` is high and `res_tgt_o` still holds the first target, while `wr_en_o` is low. After the following edge it checks that `res_valid_o` has dropped. The mirror case, a matching word right after a rejected one, is judged the same way with the roles swapped.

// File: rtl/vlbc_pkg.sv
package vlbc_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;

  localparam logic [5:0]  PRIM_OP = 6'b000100;
  localparam logic [10:0] EXT_OP  = 11'b00110001101;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] tgt;
    logic [IDX_W-1:0] src;
    logic [IDX_W-1:0] cnt;
  } dec_t;
endpackage

// File: rtl/vlbc_decode.sv
module vlbc_decode
  import vlbc_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.hit = (insn_i[31:26] == PRIM_OP) && (insn_i[10:0] == EXT_OP);
    dec_o.tgt = insn_i[25:21];
    dec_o.src = insn_i[20:16];
    dec_o.cnt = insn_i[15:11];
  end
endmodule

// File: rtl/vlbc_mask_gen.sv
module vlbc_mask_gen #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned LANE_W = 64
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [VEC_W-1:0] mask_o
);
  localparam int unsigned LANES = VEC_W / LANE_W;
  localparam int unsigned BPL   = LANE_W / 8;
  localparam int unsigned SH_W  = $clog2(BPL);

  logic [SH_W-1:0]   part_bytes;
  logic [SH_W+2:0]   part_bits;
  logic [LANE_W-1:0] partial;

  // ones in the low (count mod BPL) bytes of a lane
  assign part_bytes = cnt_i[SH_W-1:0];
  assign part_bits  = {part_bytes, 3'b000};
  assign partial    = ~({LANE_W{1'b1}} << part_bits);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [CNT_W-1:0] LO = CNT_W'(k * BPL);
    localparam logic [CNT_W-1:0] HI = CNT_W'((k + 1) * BPL);
    always_comb begin
      if (cnt_i < LO)       mask_o[k*LANE_W +: LANE_W] = '0;
      else if (cnt_i < HI)  mask_o[k*LANE_W +: LANE_W] = partial;
      else                  mask_o[k*LANE_W +: LANE_W] = '1;
    end
  end
endmodule

// File: rtl/vlbc_apply.sv
module vlbc_apply #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] mask_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int unsigned NBYTES = VEC_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign res_o[b*8 +: 8] = src_i[b*8 +: 8] & mask_i[b*8 +: 8];
  end
endmodule

// File: rtl/vlbc_unit.sv
module vlbc_unit
  import vlbc_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned LANE_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                insn_valid_i,
  input  logic [INSN_W-1:0]   insn_i,
  input  logic [VEC_W-1:0]    vsrc_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [IDX_W-1:0]    tgt_idx_o,
  output logic [IDX_W-1:0]    src_idx_o,
  output logic [IDX_W-1:0]    cnt_idx_o,
  output logic [VEC_W-1:0]    result_o,
  output logic                wr_en_o,
  output logic                res_valid_o,
  output logic [IDX_W-1:0]    res_tgt_o
);
  dec_t             dec;
  logic [VEC_W-1:0] mask;
  logic             vld_q;
  logic [IDX_W-1:0] tgt_q;

  vlbc_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  vlbc_mask_gen #(
    .VEC_W  (VEC_W),
    .CNT_W  (CNT_W),
    .LANE_W (LANE_W)
  ) u_mask (
    .cnt_i  (cnt_i),
    .mask_o (mask)
  );

  vlbc_apply #(
    .VEC_W (VEC_W)
  ) u_apply (
    .src_i  (vsrc_i),
    .mask_i (mask),
    .res_o  (result_o)
  );

  assign wr_en_o   = insn_valid_i & dec.hit;
  assign tgt_idx_o = dec.tgt;
  assign src_idx_o = dec.src;
  assign cnt_idx_o = dec.cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      vld_q <= wr_en_o;
      if (wr_en_o) tgt_q <= dec.tgt;
    end
  end

  assign res_valid_o = vld_q;
  assign res_tgt_o   = tgt_q;
endmodule

// File: rtl/vlbc_checker.sv
module vlbc_checker #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      insn_i,
  input logic [VEC_W-1:0] vsrc_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [VEC_W-1:0] result_o,
  input logic             wr_en_o,
  input logic             res_valid_o,
  input logic [4:0]       res_tgt_o
);
  localparam int unsigned HALF = VEC_W / 2;

  p_wr_en_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (insn_i[31:26] == 6'b000100 && insn_i[10:0] == 11'b00110001101));

  p_full_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i >= CNT_W'(16)) |-> (result_o == vsrc_i));

  p_zero_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (result_o == '0));

  p_high_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i < CNT_W'(8)) |-> (result_o[VEC_W-1:HALF] == '0));

  p_low_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i >= CNT_W'(8)) |-> (result_o[HALF-1:0] == vsrc_i[HALF-1:0]));

  p_valid_tgt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (res_valid_o && res_tgt_o == $past(insn_i[25:21])));

  p_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |=> !res_valid_o);
endmodule

bind vlbc_unit vlbc_checker #(
  .VEC_W (VEC_W),
  .CNT_W (CNT_W)
) u_vlbc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insn_i      (insn_i),
  .vsrc_i      (vsrc_i),
  .cnt_i       (cnt_i),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .res_valid_o (res_valid_o),
  .res_tgt_o   (res_tgt_o)
);

// File: tb/tb_vlbc_unit.sv
module tb_vlbc_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ivld = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vsrc = '0;
  logic [63:0]  cnt = '0;
  logic [4:0]   tgt_idx, src_idx, cnt_idx, res_tgt;
  logic [127:0] result;
  logic         wr_en, res_valid;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vlbc_unit dut (
    .clk_i (clk), .rst_ni (rst_n), .insn_valid_i (ivld), .insn_i (insn),
    .vsrc_i (vsrc), .cnt_i (cnt), .tgt_idx_o (tgt_idx), .src_idx_o (src_idx),
    .cnt_idx_o (cnt_idx), .result_o (result), .wr_en_o (wr_en),
    .res_valid_o (res_valid), .res_tgt_o (res_tgt)
  );

  localparam int NV = 14;
  localparam logic [63:0] CNT_TAB [NV] = '{
    64'd0, 64'd1, 64'd3, 64'd7, 64'd8, 64'd9, 64'd12, 64'd15,
    64'd16, 64'd17, 64'd24, 64'h0000_0001_0000_0002,
    64'h8000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFFF
  };
  localparam logic [127:0] SRC_TAB [NV] = '{
    128'h00112233_44556677_8899AABB_CCDDEEFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF,
    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'h11111111_22222222_33333333_44444444,
    128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C, 128'h0102030405060708090A0B0C0D0E0F10,
    128'h0102030405060708090A0B0C0D0E0F10, 128'hFFEEDDCC_BBAA9988_77665544_33221100,
    128'h13579BDF_2468ACE0_FDB97531_0ECA8642, 128'h0102030405060708090A0B0C0D0E0F10,
    128'hCAFEBABE_DEADBEEF_FEEDFACE_BAADF00D, 128'h01234567_89ABCDEF_FEDCBA98_76543210
  };

  function automatic logic [31:0] mk(input logic [4:0] t, input logic [4:0] s,
                                     input logic [4:0] r);
    return {6'b000100, t, s, r, 11'b00110001101};
  endfunction

  // big-endian bytes: byte i is bits [127-8i -: 8]; keep bytes 16-N..15
  function automatic logic [127:0] exp_res(input logic [127:0] s, input logic [63:0] n);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++)
      if (n >= 64'd16 || 64'(15 - i) < n) r[127-8*i -: 8] = s[127-8*i -: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] w, input logic [127:0] s,
                       input logic [63:0] n);
    @(negedge clk);
    ivld = v; insn = w; vsrc = s; cnt = n;
    #1;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state (R9)
    repeat (3) @(posedge clk);
    #1 chk("R9 reset valid", 128'(res_valid), 128'd0);
    @(negedge clk); rst_n = 1'b1;

    // table walk (R3..R8)
    for (int k = 0; k < NV; k++) begin
      logic [4:0] t = 5'(k + 3);
      issue(1'b1, mk(t, 5'(k), 5'(31 - k)), SRC_TAB[k], CNT_TAB[k]);
      chk("R7 table result", result, exp_res(SRC_TAB[k], CNT_TAB[k]));
      if (CNT_TAB[k] == 0)        chk("R4 zero", result, 128'd0);
      else if (CNT_TAB[k] < 8)    chk("R5 high clear", 128'(result[127:64]), 128'd0);
      else if (CNT_TAB[k] < 16)   chk("R6 low keep", 128'(result[63:0]), 128'(SRC_TAB[k][63:0]));
      else                        chk("R3 full keep", result, SRC_TAB[k]);
      chk("R1 wr_en", 128'(wr_en), 128'd1);
      chk("R2 fields", 128'({tgt_idx, src_idx, cnt_idx}), 128'({t, 5'(k), 5'(31 - k)}));
      @(posedge clk); #1;
      chk("R8 valid", 128'(res_valid), 128'd1);
      chk("R8 tgt", 128'(res_tgt), 128'(t));
    end

    // byte positions for every count 0..16 (R7)
    for (int n = 0; n <= 16; n++) begin
      logic [127:0] s = 128'h0102030405060708090A0B0C0D0E0F10;
      logic [127:0] e = '0;
      for (int i = 16 - n; i < 16; i++) e[127-8*i -: 8] = 8'(i + 1);
      issue(1'b1, mk(5'd1, 5'd2, 5'd3), s, 64'(n));
      chk("R7 byte order", result, e);
    end

    // decode rejects (R1, R9)
    issue(1'b1, mk(5'd4, 5'd5, 5'd6) ^ 32'h0000_0001, SRC_TAB[0], 64'd5);
    chk("R1 ext mismatch", 128'(wr_en), 128'd0);
    @(posedge clk); #1 chk("R9 no valid ext", 128'(res_valid), 128'd0);
    issue(1'b1, mk(5'd4, 5'd5, 5'd6) ^ 32'h8000_0000, SRC_TAB[0], 64'd5);
    chk("R1 prim mismatch", 128'(wr_en), 128'd0);
    chk("R2 fields on reject", 128'({tgt_idx, src_idx, cnt_idx}), 128'({5'd4, 5'd5, 5'd6}));
    issue(1'b0, mk(5'd4, 5'd5, 5'd6), SRC_TAB[0], 64'd5);
    chk("R1 valid low", 128'(wr_en), 128'd0);
    @(posedge clk); #1 chk("R9 no valid idle", 128'(res_valid), 128'd0);

    // overlap: completion flag of one with a rejected next word (R8, R9)
    issue(1'b1, mk(5'd27, 5'd1, 5'd2), SRC_TAB[1], 64'd4);
    issue(1'b1, 32'hDEAD_BEEF, SRC_TAB[1], 64'd4);
    chk("R8 overlap valid", 128'(res_valid), 128'd1);
    chk("R8 overlap tgt", 128'(res_tgt), 128'd27);
    chk("R1 overlap wr_en", 128'(wr_en), 128'd0);
    issue(1'b1, mk(5'd9, 5'd1, 5'd2), SRC_TAB[1], 64'd20);
    chk("R9 overlap drop", 128'(res_valid), 128'd0);
    chk("R1 overlap next", 128'(wr_en), 128'd1);
    @(posedge clk); #1 chk("R8 after reject tgt", 128'(res_tgt), 128'd9);

    // async reset mid-run (R9)
    issue(1'b1, mk(5'd2, 5'd1, 5'd2), SRC_TAB[1], 64'd3);
    @(posedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R9 async reset", 128'(res_valid), 128'd0);
    ivld = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule